// File: doc/BRIEF.md
# Wake Pin Interrupt Controller

This block watches a small set of asynchronous wake pins and turns each one into an interrupt. Every pin has its own trigger mode: active-low level, active-high level, falling edge, rising edge, any edge, or no detection. Each pin passes through a synchronizer before detection. The controller keeps a status bit, an enable bit and a write-one-to-clear bit for each pin.

A single routing register decides where each source goes. The sources are the wake pins plus three fixed peripheral interrupt lines: a real-time clock, an infrared receiver and a watchdog. A source can drive the external interrupt output, the wake-up request output, or both. Software reaches all state through a simple single-cycle 32-bit register bus with a 12-bit byte address. Reads are combinational from the address.

Top module: `wake_pin_intc`

## Requirements
- R1: While reset is held and right after it, every register reads zero and both `ext_irq` and `wake_req` are low.
- R2: Register map (byte addresses):
  - Status (0x310) holds pins in bits 3:0 and is read-only.
  - Enable (0x314) has writable bits 3:0.
  - Clear (0x318) always reads zero.
  - Route (0x31C) keeps only bits 0-2, 8-11, 16-18 and 24-27.
  - Any address outside the map reads zero.
- R3: The configuration register of pin n sits at 0x330 + 8*n:
  - bits 3:1 hold the trigger mode, and bit 4 is a plain read/write control bit;
  - bit 0 returns the synchronized pin value, two clocks after the pin changes.
- R4: In mode 0 the status bit follows a low synchronized pin, and in mode 1 it follows a high one. Writing a 1 to the pin's clear bit has no lasting effect while that level is present.
- R5: In mode 2 a falling edge sets the status bit, in mode 3 a rising edge sets it, and in mode 6 any change sets it. The bit then stays set until a 1 is written to the pin's bit of the clear register.
- R6: In mode 4 (and the unused codes 5 and 7) the status bit never becomes set, whatever the pin does.
- R7: `ext_irq` is the OR of every pin whose status and enable bits are both set and whose route bit 8+n is set. It also ORs in every peripheral input i (0 = clock, 1 = infrared, 2 = watchdog) whose route bit i is set.
- R8: `wake_req` is the OR of every pin whose status bit is set and whose route bit 24+n is set, regardless of the enable register. It also ORs in every peripheral input i whose route bit 16+i is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 12 | Byte address for reads and writes |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| wake_pin | input | NUM_WAKE | Asynchronous wake pins |
| periph_irq | input | NUM_PERIPH | Peripheral interrupt lines (clock, infrared, watchdog) |
| ext_irq | output | 1 | External interrupt output |
| wake_req | output | 1 | Wake-up request output |

## Verification
The assertions assume that the peripheral lines are already synchronous to `clk`. They also assume that a configuration write and a clear write to the same pin never land in the same cycle. The stimulus respects both assumptions: it drives every input on the falling clock edge and issues one bus write at a time. Pins are held steady for at least four clocks around each mode change, so every edge the checks count is a deliberate one.

// File: rtl/wpic_pkg.sv
package wpic_pkg;
  localparam logic [11:0] A_STAT  = 12'h310;
  localparam logic [11:0] A_EN    = 12'h314;
  localparam logic [11:0] A_CLR   = 12'h318;
  localparam logic [11:0] A_ROUTE = 12'h31C;
  localparam logic [11:0] A_CFG0  = 12'h330;
  localparam int CFG_STRIDE   = 8;
  localparam int EXT_PER_LSB  = 0;
  localparam int EXT_PIN_LSB  = 8;
  localparam int WAKE_PER_LSB = 16;
  localparam int WAKE_PIN_LSB = 24;

  localparam logic [2:0] TRIG_LO   = 3'd0;
  localparam logic [2:0] TRIG_HI   = 3'd1;
  localparam logic [2:0] TRIG_FALL = 3'd2;
  localparam logic [2:0] TRIG_RISE = 3'd3;
  localparam logic [2:0] TRIG_OFF  = 3'd4;
  localparam logic [2:0] TRIG_ANY  = 3'd6;

  function automatic logic [11:0] cfg_addr(int n);
    return A_CFG0 + 12'(CFG_STRIDE * n);
  endfunction

  function automatic logic is_level(logic [2:0] m);
    return (m == TRIG_LO) || (m == TRIG_HI);
  endfunction

  function automatic logic trig_hit(logic [2:0] m, logic prev, logic cur);
    case (m)
      TRIG_LO:   return !cur;
      TRIG_HI:   return cur;
      TRIG_FALL: return prev && !cur;
      TRIG_RISE: return !prev && cur;
      TRIG_ANY:  return prev ^ cur;
      default:   return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] route_mask(int nw, int np);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < np; i++) begin
      m[EXT_PER_LSB + i]  = 1'b1;
      m[WAKE_PER_LSB + i] = 1'b1;
    end
    for (int i = 0; i < nw; i++) begin
      m[EXT_PIN_LSB + i]  = 1'b1;
      m[WAKE_PIN_LSB + i] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/wpic_sync.sv
module wpic_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) st[k] <= '0;
    end else begin
      st[0] <= d;
      for (int k = 1; k < STAGES; k++) st[k] <= st[k-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/wpic_pin.sv
module wpic_pin
  import wpic_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_s,
  input  logic [2:0] mode,
  input  logic       clr,
  output logic       hit,
  output logic       status
);
  logic prev_q;
  logic level;

  assign hit   = trig_hit(mode, prev_q, pin_s);
  assign level = is_level(mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      status <= 1'b0;
    end else begin
      prev_q <= pin_s;
      if (level) status <= hit;
      else       status <= hit | (status & ~clr);
    end
  end
endmodule

// File: rtl/wake_pin_intc.sv
module wake_pin_intc
  import wpic_pkg::*;
#(
  parameter int NUM_WAKE    = 4,
  parameter int NUM_PERIPH  = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [11:0]           bus_addr,
  input  logic                  bus_we,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  input  logic [NUM_WAKE-1:0]   wake_pin,
  input  logic [NUM_PERIPH-1:0] periph_irq,
  output logic                  ext_irq,
  output logic                  wake_req
);
  localparam logic [31:0] ROUTE_KEEP = route_mask(NUM_WAKE, NUM_PERIPH);

  logic [NUM_WAKE-1:0]   pin_s;
  logic [NUM_WAKE-1:0]   pin_hit;
  logic [NUM_WAKE-1:0]   status_q;
  logic [NUM_WAKE-1:0]   en_q;
  logic [NUM_WAKE-1:0]   clr_vec;
  logic [NUM_WAKE-1:0]   level_vec;
  logic [NUM_WAKE-1:0]   off_vec;
  logic [NUM_WAKE-1:0]   cfg_we_vec;
  logic [31:0]           route_q;
  logic [2:0]            cfg_mode [NUM_WAKE];
  logic [NUM_WAKE-1:0]   cfg_ctl;
  logic [NUM_WAKE-1:0]   ext_pin_hit, wake_pin_hit;
  logic [NUM_PERIPH-1:0] ext_per_hit, wake_per_hit;

  wpic_sync #(.W(NUM_WAKE), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(wake_pin), .q(pin_s)
  );

  assign clr_vec = (bus_we && bus_addr == A_CLR) ? bus_wdata[NUM_WAKE-1:0] : '0;

  for (genvar n = 0; n < NUM_WAKE; n++) begin : g_pin
    assign cfg_we_vec[n] = bus_we && (bus_addr == cfg_addr(n));
    assign level_vec[n]  = is_level(cfg_mode[n]);
    assign off_vec[n]    = !level_vec[n] && cfg_mode[n] != TRIG_FALL &&
                           cfg_mode[n] != TRIG_RISE && cfg_mode[n] != TRIG_ANY;
    wpic_pin u_pin (
      .clk(clk), .rst_n(rst_n), .pin_s(pin_s[n]), .mode(cfg_mode[n]),
      .clr(clr_vec[n]), .hit(pin_hit[n]), .status(status_q[n])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      route_q <= '0;
      cfg_ctl <= '0;
      for (int n = 0; n < NUM_WAKE; n++) cfg_mode[n] <= '0;
    end else begin
      if (bus_we && bus_addr == A_EN)    en_q    <= bus_wdata[NUM_WAKE-1:0];
      if (bus_we && bus_addr == A_ROUTE) route_q <= bus_wdata & ROUTE_KEEP;
      for (int n = 0; n < NUM_WAKE; n++) begin
        if (cfg_we_vec[n]) begin
          cfg_mode[n] <= bus_wdata[3:1];
          cfg_ctl[n]  <= bus_wdata[4];
        end
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_STAT)       bus_rdata[NUM_WAKE-1:0] = status_q;
    else if (bus_addr == A_EN)    bus_rdata[NUM_WAKE-1:0] = en_q;
    else if (bus_addr == A_ROUTE) bus_rdata = route_q;
    for (int n = 0; n < NUM_WAKE; n++) begin
      if (bus_addr == cfg_addr(n))
        bus_rdata = {27'd0, cfg_ctl[n], cfg_mode[n], pin_s[n]};
    end
  end

  assign ext_pin_hit  = status_q & en_q & route_q[EXT_PIN_LSB +: NUM_WAKE];
  assign wake_pin_hit = status_q & route_q[WAKE_PIN_LSB +: NUM_WAKE];
  assign ext_per_hit  = periph_irq & route_q[EXT_PER_LSB +: NUM_PERIPH];
  assign wake_per_hit = periph_irq & route_q[WAKE_PER_LSB +: NUM_PERIPH];

  assign ext_irq  = (|ext_pin_hit) | (|ext_per_hit);
  assign wake_req = (|wake_pin_hit) | (|wake_per_hit);
endmodule

// File: rtl/wpic_chk.sv
module wpic_chk
  import wpic_pkg::*;
#(
  parameter int NW = 4,
  parameter int NP = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ext_irq,
  input logic          wake_req,
  input logic [NW-1:0] status_q,
  input logic [NW-1:0] pin_hit,
  input logic [NW-1:0] clr_vec,
  input logic [NW-1:0] level_vec,
  input logic [NW-1:0] off_vec,
  input logic [NW-1:0] cfg_we_vec,
  input logic [31:0]   route_q,
  input logic [NP-1:0] periph_irq
);
  for (genvar i = 0; i < NW; i++) begin : g_c
    // R6
    off_never_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      off_vec[i] && !status_q[i] |=> !status_q[i]);
    // R5
    edge_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !level_vec[i] && !cfg_we_vec[i] && status_q[i] && !clr_vec[i] |=> status_q[i]);
    // R5
    edge_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !level_vec[i] && clr_vec[i] && !pin_hit[i] |=> !status_q[i]);
    // R4
    level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      level_vec[i] |=> status_q[i] == $past(pin_hit[i]));
  end

  // R7
  ext_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    route_q[EXT_PIN_LSB +: NW] == '0 && route_q[EXT_PER_LSB +: NP] == '0 |-> !ext_irq);
  // R8
  wake_per_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(periph_irq & route_q[WAKE_PER_LSB +: NP])) |-> wake_req);
endmodule

bind wake_pin_intc wpic_chk #(.NW(NUM_WAKE), .NP(NUM_PERIPH)) u_chk (
  .clk(clk), .rst_n(rst_n), .ext_irq(ext_irq), .wake_req(wake_req),
  .status_q(status_q), .pin_hit(pin_hit), .clr_vec(clr_vec),
  .level_vec(level_vec), .off_vec(off_vec), .cfg_we_vec(cfg_we_vec),
  .route_q(route_q), .periph_irq(periph_irq)
);

// File: tb/wake_pin_intc_test.sv
`timescale 1ns/1ps
module wake_pin_intc_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  wake_pin = '0;
  logic [2:0]  periph_irq = '0;
  logic        ext_irq, wake_req;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  wake_pin_intc uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wake_pin(wake_pin),
    .periph_irq(periph_irq), .ext_irq(ext_irq), .wake_req(wake_req)
  );

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] caddr(int n);
    return 12'h330 + 12'(8 * n);
  endfunction

  // expected status after the pin moves a->b in a given mode
  function automatic logic expect_stat(int m, logic a, logic b);
    if (m == 0) return b == 1'b0;
    if (m == 1) return b == 1'b1;
    if (m == 2) return a & ~b;
    if (m == 3) return ~a & b;
    if (m == 6) return a != b;
    return 1'b0;
  endfunction

  initial begin
    #100000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int modes [6] = '{0, 1, 2, 3, 6, 4};
    tick(2);
    // R1: reset state
    rd(12'h310, v); chk("R1 status", v, 0);
    rd(12'h314, v); chk("R1 enable", v, 0);
    rd(12'h31C, v); chk("R1 route", v, 0);
    rd(caddr(0), v); chk("R1 cfg0", v, 0);
    chk("R1 ext_irq", {31'd0, ext_irq}, 0);
    chk("R1 wake_req", {31'd0, wake_req}, 0);
    @(negedge clk); rst_n = 1'b1;
    for (int n = 0; n < 4; n++) wr(caddr(n), 32'h8);
    wr(12'h318, 32'hF);
    tick(2);

    // R2: register masks and read-only behaviour
    wr(12'h31C, 32'hFFFF_FFFF); rd(12'h31C, v); chk("R2 route mask", v, 32'h0F07_0F07);
    wr(12'h31C, 0);
    wr(12'h314, 32'hFFFF_FFFF); rd(12'h314, v); chk("R2 enable mask", v, 32'hF);
    wr(12'h314, 0);
    wr(12'h310, 32'hF); rd(12'h310, v); chk("R2 status read-only", v, 0);
    rd(12'h318, v); chk("R2 clear reads zero", v, 0);
    rd(12'h320, v); chk("R2 unmapped", v, 0);
    // R3: config fields
    wr(caddr(1), 32'hFFFF_FFFF); rd(caddr(1), v); chk("R3 cfg fields", v, 32'h1E);
    wr(caddr(1), 32'h8); wr(12'h318, 32'hF);
    wake_pin[2] = 1'b1; tick(1); rd(caddr(2), v); chk("R3 not yet synced", v, 32'h8);
    tick(1); rd(caddr(2), v); chk("R3 synced pin bit", v, 32'h9);
    wake_pin[2] = 1'b0; tick(4);

    // R4 R5 R6: mode sweep over all pins and both transitions
    for (int p = 0; p < 4; p++) begin
      for (int mi = 0; mi < 6; mi++) begin
        for (int t = 0; t < 2; t++) begin
          logic a, b;
          a = t[0]; b = ~a;
          wake_pin[p] = a;
          wr(caddr(p), 32'h8); tick(4); wr(12'h318, 32'h1 << p);
          wr(caddr(p), 32'(modes[mi]) << 1); tick(4);
          wr(12'h318, 32'h1 << p); tick(2);
          if (modes[mi] < 2) begin
            rd(12'h310, v);
            chk("R4 clear ineffective under level", {31'd0, v[p]},
                {31'd0, expect_stat(modes[mi], a, a)});
          end
          wake_pin[p] = b; tick(4);
          rd(12'h310, v);
          chk(modes[mi] < 2 ? "R4 level status" : (modes[mi] == 4 ? "R6 off status" : "R5 edge status"),
              {31'd0, v[p]}, {31'd0, expect_stat(modes[mi], a, b)});
          rd(caddr(p), v);
          chk("R3 cfg readback", v, (32'(modes[mi]) << 1) | {31'd0, b});
        end
      end
      wr(caddr(p), 32'h8); wake_pin[p] = 1'b0; tick(4);
    end
    wr(12'h318, 32'hF); tick(1);

    // R7 R8: pin routing with rising edge on pin 0
    wr(caddr(0), 32'h6);
    wr(12'h31C, 32'h100);
    wake_pin[0] = 1'b1; tick(4); #1;
    chk("R7 not enabled", {31'd0, ext_irq}, 0);
    wr(12'h31C, 32'h0100_0100); #1;
    chk("R8 wake without enable", {31'd0, wake_req}, 1);
    wr(12'h314, 32'h1); #1;
    chk("R7 enabled pin", {31'd0, ext_irq}, 1);
    wake_pin[0] = 1'b0; tick(4); rd(12'h310, v);
    chk("R5 sticky after pin drops", v, 32'h1);
    wr(12'h318, 32'h1); #1;
    chk("R5 cleared ext", {31'd0, ext_irq}, 0);
    chk("R8 cleared wake", {31'd0, wake_req}, 0);
    wr(12'h314, 0); wr(caddr(0), 32'h8);

    // R7 R8: peripheral routing sweep
    for (int r = 0; r < 8; r++) begin
      wr(12'h31C, 32'(r));
      for (int pv = 0; pv < 8; pv++) begin
        periph_irq = 3'(pv); #1;
        chk("R7 periph ext", {31'd0, ext_irq}, {31'd0, |(3'(pv) & 3'(r))});
        chk("R8 periph no wake", {31'd0, wake_req}, 0);
      end
      wr(12'h31C, 32'(r) << 16);
      for (int pv = 0; pv < 8; pv++) begin
        periph_irq = 3'(pv); #1;
        chk("R8 periph wake", {31'd0, wake_req}, {31'd0, |(3'(pv) & 3'(r))});
        chk("R7 periph no ext", {31'd0, ext_irq}, 0);
      end
    end
    periph_irq = '0;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule